// File: doc/BRIEF.md
# Third-Order Decimating Filter with Rate Codes

This block sits behind a sigma-delta modulator and turns its fast, few-bit sample stream into slower, wide, signed output words. It is a third-order cascaded integrator-comb filter: three running-sum stages take in every accepted sample, and three differencing stages run once per output word. The modulator usually runs at 512 kHz, or at about 131 kHz in the low-power clocking. Every output rate scales with that input rate, because the filter counts samples and never looks at time.

A 7-bit rate code sets how many input samples make one output word. Codes 0 to 125 give (code+1)×64 samples. The top two codes are kept for fixed mains-rejection rates: 126 gives about 60 words per second and 127 gives exactly 50 words per second at the nominal input rate. Samples come in on a valid/ready stream and words go out on a valid/ready stream. A flag marks words produced before the filter memory has filled again after a reset or a change of rate code.

Back-pressure rules: an input sample is taken on a clock edge only while `in_valid` and `in_ready` are both high. An output word is handed over on an edge while `out_valid` and `out_ready` are both high. Once `out_valid` is high, it and `out_data` stay fixed until the word is taken. For as long as a word waits, `in_ready` is low. The input stream therefore stalls instead of losing a word.

Top module: `sinc3_decimator`

## Requirements
- R1: For rate codes 0 to 125, exactly (code+1)×64 accepted input samples lie between two output words, and the first word after a flush also needs that many.
- R2: Rate code 126 (binary 1111110) produces one output word every 8533 accepted samples.
- R3: Rate code 127 (binary 1111111) produces one output word every 10240 accepted samples.
- R4: With a constant input value x (two's complement, IN_W bits), the fourth and every later word after a flush equal x·N³ as a signed ACC_W-bit number, where N is the decimation ratio.
- R5: With a constant input value x, the first word after a flush equals x·N(N+1)(N+2)/6.
- R6: `out_settled` is 0 on the first three words after a reset or a flush, and 1 on every later word.
- R7: A rate code that differs from the code in use flushes the filter on the next edge. `in_ready` is low during that cycle, a waiting output word is dropped, and the sample counter and all filter state restart from zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays unchanged and `in_ready` is low.
- R9: While `out_ready` is held high, `out_valid` is high for a single cycle per word.
- R10: After reset, `out_valid`, `out_settled` and `out_data` are all zero.
- R11: Cycles in which `in_valid` is low do not advance the filter or the sample count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code | input | 7 | Decimation code; a change triggers a flush |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W (2) | Signed modulator sample |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_data | output | ACC_W (44) | Signed filtered word |
| out_settled | output | 1 | Word came after the filter memory refilled |

## Verification
Assertions inside the modules check the handshake on every cycle. They check that a waiting word holds its value and stalls the input, and that a flush drops any waiting word and never lines up with an accepted sample. They also check that the sample counter stays below the decoded ratio and that the settled flag agrees with the count of words since the last flush. Only the bench scenarios can show that the numbers are right: the ratio decoded for ordinary and reserved codes, the exact first and steady-state values for constant inputs, the behaviour with gaps in the input stream, and the restart after a flush.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
  // width of the rate code field
  localparam int CODE_W     = 7;
  // ordinary codes scale the ratio by 2**BASE_SHIFT
  localparam int BASE_SHIFT = 6;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sinc3_rate_decode.sv
`timescale 1ns/1ps
module sinc3_rate_decode #(
  parameter int CODE_W     = 7,
  parameter int BASE_SHIFT = 6,
  parameter int RATIO_W    = 14,
  parameter int DECIM_HI   = 8533,
  parameter int DECIM_LO   = 10240
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio
);
  localparam logic [CODE_W-1:0] CODE_LO = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_HI = {{(CODE_W-1){1'b1}}, 1'b0};

  always_comb begin
    if (code == CODE_LO)
      ratio = RATIO_W'(DECIM_LO);
    else if (code == CODE_HI)
      ratio = RATIO_W'(DECIM_HI);
    else
      ratio = RATIO_W'((RATIO_W'(code) + RATIO_W'(1)) << BASE_SHIFT);
  end
endmodule

// File: rtl/sinc3_integ_chain.sv
`timescale 1ns/1ps
module sinc3_integ_chain #(
  parameter int IN_W  = 2,
  parameter int ACC_W = 44,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic signed [IN_W-1:0]  in_data,
  output logic signed [ACC_W-1:0] sum_next
);
  logic signed [ACC_W-1:0] st [ORDER];
  logic signed [ACC_W-1:0] nx [ORDER+1];

  assign nx[0] = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    // wraparound add; the final comb result is exact modulo 2**ACC_W
    assign nx[g+1] = st[g] + nx[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st[g] <= '0;
      else if (clear) st[g] <= '0;
      else if (step)  st[g] <= nx[g+1];
    end
  end

  assign sum_next = nx[ORDER];

  // R7: a flush cycle never takes a sample into the integrators
  assert_no_step_in_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && step));
endmodule

// File: rtl/sinc3_comb_chain.sv
`timescale 1ns/1ps
module sinc3_comb_chain #(
  parameter int ACC_W = 44,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    dump,
  input  logic signed [ACC_W-1:0] in_sum,
  output logic signed [ACC_W-1:0] diff_out
);
  logic signed [ACC_W-1:0] dl [ORDER];
  logic signed [ACC_W-1:0] df [ORDER+1];

  assign df[0] = in_sum;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    assign df[g+1] = df[g] - dl[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dl[g] <= '0;
      else if (clear) dl[g] <= '0;
      else if (dump)  dl[g] <= df[g];
    end
  end

  assign diff_out = df[ORDER];

  // R7: the comb memory is never updated in the cycle that clears it
  assert_no_dump_in_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && dump));
endmodule

// File: rtl/sinc3_decim_ctrl.sv
`timescale 1ns/1ps
module sinc3_decim_ctrl #(
  parameter int CODE_W  = 7,
  parameter int RATIO_W = 14,
  parameter int ORDER   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  rate_code,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               in_valid,
  input  logic               out_ready,
  output logic [CODE_W-1:0]  code_q,
  output logic               flush,
  output logic               accept,
  output logic               dump,
  output logic               in_ready,
  output logic               out_valid,
  output logic               out_settled
);
  localparam int SET_W = $clog2(ORDER + 1);

  logic [RATIO_W-1:0] cnt;
  logic [SET_W-1:0]   settle_cnt;
  logic               last;

  assign flush    = (rate_code != code_q);
  assign in_ready = !flush && !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;
  assign last     = (cnt == ratio - RATIO_W'(1));
  assign dump     = accept && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q      <= '0;
      cnt         <= '0;
      settle_cnt  <= '0;
      out_valid   <= 1'b0;
      out_settled <= 1'b0;
    end else if (flush) begin
      code_q      <= rate_code;
      cnt         <= '0;
      settle_cnt  <= '0;
      out_valid   <= 1'b0;
      out_settled <= 1'b0;
    end else begin
      if (accept) cnt <= last ? '0 : cnt + RATIO_W'(1);
      if (dump) begin
        out_valid   <= 1'b1;
        out_settled <= (settle_cnt == SET_W'(ORDER));
        if (settle_cnt != SET_W'(ORDER)) settle_cnt <= settle_cnt + SET_W'(1);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: the sample counter stays inside the decoded ratio
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);
  // R8: a waiting word stalls the input stream
  assert_stall_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R8: a waiting word stays offered unless a flush drops it
  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> out_valid);
  // R7: a flush removes any word that was offered
  assert_flush_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  // R9: a taken word is not offered again on the next cycle
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  // R6: a settled word only appears once the refill count is complete
  assert_settled_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_settled) |-> (settle_cnt == SET_W'(ORDER)));
endmodule

// File: rtl/sinc3_decimator.sv
`timescale 1ns/1ps
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int IN_W       = 2,
  parameter int ORDER      = 3,
  parameter int MOD_HZ     = 512000,
  parameter int MAINS_HI_HZ = 60,
  parameter int MAINS_LO_HZ = 50,
  localparam int DECIM_HI  = MOD_HZ / MAINS_HI_HZ,
  localparam int DECIM_LO  = MOD_HZ / MAINS_LO_HZ,
  localparam int MAX_DECIM = max3(DECIM_HI, DECIM_LO, ((2**CODE_W) - 2) << BASE_SHIFT),
  localparam int RATIO_W   = $clog2(MAX_DECIM + 1),
  localparam int ACC_W     = IN_W + ORDER * RATIO_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CODE_W-1:0]       rate_code,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_data,
  output logic                    out_settled
);
  logic [CODE_W-1:0]       code_q;
  logic [RATIO_W-1:0]      ratio;
  logic                    flush, accept, dump;
  logic signed [ACC_W-1:0] integ_sum, comb_out;

  sinc3_rate_decode #(
    .CODE_W(CODE_W), .BASE_SHIFT(BASE_SHIFT), .RATIO_W(RATIO_W),
    .DECIM_HI(DECIM_HI), .DECIM_LO(DECIM_LO)
  ) u_decode (
    .code(code_q), .ratio(ratio)
  );

  sinc3_decim_ctrl #(.CODE_W(CODE_W), .RATIO_W(RATIO_W), .ORDER(ORDER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .ratio(ratio),
    .in_valid(in_valid), .out_ready(out_ready), .code_q(code_q),
    .flush(flush), .accept(accept), .dump(dump), .in_ready(in_ready),
    .out_valid(out_valid), .out_settled(out_settled)
  );

  sinc3_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_n(rst_n), .clear(flush), .step(accept),
    .in_data(in_data), .sum_next(integ_sum)
  );

  sinc3_comb_chain #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst_n(rst_n), .clear(flush), .dump(dump),
    .in_sum(integ_sum), .diff_out(comb_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_data <= '0;
    else if (dump) out_data <= comb_out;
  end

  // R8: a waiting word keeps its value
  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
  // R1: the decoded ratio never leaves its legal span
  assert_ratio_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RATIO_W'(1 << BASE_SHIFT)) && (ratio <= RATIO_W'(MAX_DECIM)));
endmodule

// File: tb/sinc3_decimator_tb.sv
`timescale 1ns/1ps
module sinc3_decimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 2;
  localparam int ACC_W = 44;
  localparam int WATCHDOG = 190000;
  localparam int NCASE = 6;
  localparam logic [6:0] T_CODE [NCASE] = '{7'd3, 7'd0, 7'd1, 7'd125, 7'd126, 7'd127};
  localparam int         T_X    [NCASE] = '{-1, 1, -2, 1, 1, -2};
  localparam bit         T_GAP  [NCASE] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] rate_code = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [ACC_W-1:0] out_data;
  logic out_settled;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [6:0] cur_code = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sinc3_decimator u_dut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_settled(out_settled)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ratio_of(input logic [6:0] c);
    if (c == 7'd127) return 10240;
    if (c == 7'd126) return 8533;
    return (longint'(c) + 1) * 64;
  endfunction

  function automatic string ratio_req(input logic [6:0] c);
    if (c == 7'd127) return "R3";
    if (c == 7'd126) return "R2";
    return "R1";
  endfunction

  // switch to a code, feed constant x and check nout words
  task automatic run_case(input logic [6:0] code, input int x, input int nout, input bit gaps);
    longint n, acc, last_acc, got;
    int k, cyc;
    bit prev_v;
    n = ratio_of(code);
    acc = 0; last_acc = 0; k = 0; cyc = 0; prev_v = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    rate_code = code;
    #1;
    if (code != cur_code) check(in_ready == 1'b0, "R7 in_ready in flush cycle", in_ready, 0);
    cur_code = code;
    while (k < nout) begin
      @(negedge clk);
      if (out_valid) begin
        k++;
        got = longint'(out_data);
        check(!prev_v, "R9 valid lasts one cycle", 1, 0);
        check(acc - last_acc == n, ratio_req(code), acc - last_acc, n);
        if (gaps) check(acc - last_acc == n, "R11 gaps do not advance count", acc - last_acc, n);
        last_acc = acc;
        check(out_settled == (k > 3), "R6 settled flag", out_settled, (k > 3));
        if (k == 1) check(got == x * (n * (n + 1) * (n + 2) / 6), "R5 first word", got,
                          x * (n * (n + 1) * (n + 2) / 6));
        if (k >= 4) check(got == x * n * n * n, "R4 steady word", got, x * n * n * n);
      end
      prev_v = out_valid;
      in_valid = gaps ? (cyc % 3 != 0) : 1'b1;
      in_data = IN_W'(x);
      cyc++;
      #1;
      if (in_valid && in_ready) acc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    longint held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: outputs after reset
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(out_settled == 1'b0, "R10 out_settled after reset", out_settled, 0);
    check(out_data == '0, "R10 out_data after reset", longint'(out_data), 0);

    for (int i = 0; i < NCASE; i++) run_case(T_CODE[i], T_X[i], 4, T_GAP[i]);

    // R8: back-pressure holds the word and stalls the input
    @(negedge clk);
    out_ready = 1'b0;
    rate_code = 7'd2;
    cur_code = 7'd2;
    in_valid = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = IN_W'(1);
    while (!out_valid) @(negedge clk);
    held = longint'(out_data);
    check(held == 192 * 193 * 194 / 6, "R5 first word code 2", held, 192 * 193 * 194 / 6);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      check(longint'(out_data) == held, "R8 data held", longint'(out_data), held);
      check(in_ready == 1'b0, "R8 input stalled", in_ready, 0);
    end
    // R7: a code change drops the waiting word and clears the filter
    rate_code = 7'd4;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 waiting word dropped", out_valid, 0);
    cur_code = 7'd4;
    run_case(7'd4, 1, 2, 1'b0);

    finish_run();
  end
endmodule